// File: doc/BRIEF.md
# ADC Sample Serializer

This block turns parallel conversion samples from several channels into serial lane streams. Each channel receives its sample through a valid/data pair. The block sends that sample on one or two serial wires. It also drives a frame clock that marks sample boundaries and a bit clock that a receiver uses to capture the bits. The block runs from one fast clock `clk`. Every bit slot lasts two `clk` cycles. This makes it possible to build a bit clock at the bit rate (single data rate) or at half the bit rate (double data rate) from registers alone.

Configuration inputs choose the following:
- the lane arrangement: one wire with a double-rate clock, two wires with a single-rate clock, or two wires with a double-rate clock;
- a 12-bit short frame, which applies only to the two-wire single-rate arrangement;
- the capture edge the receiver should use;
- the bit order;
- two's complement or offset binary output.

A two-bit mode input chooses the output content: live data, a frame-alignment training word, an alternating training pattern for edge checks, or a full stop with quiet outputs. The block samples all settings, the mode included, only when a frame starts. A frame is therefore never sent half in one setting and half in another.

Top module: `adc_serializer`

## Requirements
- R1: While `rst` is high, every lane, `bclk_o` and `fclk_o` are 0. After `rst` falls with mode 00, the first frame carries the held sample, which is 0 if no sample was received.
- R2: Mode 10 stops the block at the next frame boundary. From then on all lanes, `bclk_o` and `fclk_o` stay 0 with no toggling. When mode leaves 10, a complete new frame begins within one cycle.
- R3: A lane sends m bits per frame, each bit for two `clk` cycles, so a frame lasts 2m cycles. `fclk_o` is 1 for the first m cycles of the frame and 0 for the last m. One-wire frames use m = 14. Two-wire frames use m = 7, or m = 6 when the short frame applies.
- R4: The short frame (`short_frame_i` = 1) applies only when `lane_sel_i` = 10. It then sends the low 12 bits of the sample. For any other lane code, `short_frame_i` has no effect and all 14 bits are sent.
- R5: With `lane_sel_i` = 10 (single rate), `bclk_o` completes one period per bit slot. It rises mid-slot when `cap_rise_i` = 1 and falls mid-slot when `cap_rise_i` = 0.
- R6: With a double-rate lane code, `bclk_o` changes exactly once per bit slot, in the middle of the slot, and never where the data changes.
- R7: With lane code 00, lane A sends the n-bit word, msb first when `lsb_first_i` = 0 and lsb first when it is 1. Lane B stays 0.
- R8: With lane codes 10 and 11, lane A sends bits n-1..n/2 and lane B sends bits n/2-1..0, each in the chosen order.
- R9: With `offset_bin_i` = 1, the sent word is the sample with bit n-1 inverted. Otherwise the sample is sent unchanged.
- R10: Mode 01 sends on every active lane, on all channels, a 1 in bits k < ceil(m/2) and a 0 in the rest of the frame. An unused lane B stays 0.
- R11: Mode 11 sends on every active lane a pattern that alternates 1/0 on each bit slot, identical on lanes A and B. An unused lane B stays 0.
- R12: A change to any configuration or mode input in the middle of a frame leaves the rest of that frame unchanged. The change takes effect from the next frame.
- R13: Lane code 01 behaves exactly like lane code 00.
- R14: Each channel keeps its last valid sample. Every frame resends that held sample until a new valid sample arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two cycles per bit slot |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 data, 01 alignment word, 10 stop, 11 alternating pattern |
| lane_sel_i | input | 2 | 00/01 one wire double rate, 10 two wires single rate, 11 two wires double rate |
| short_frame_i | input | 1 | 12-bit frame (only with lane code 10) |
| cap_rise_i | input | 1 | Receiver captures on the rising edge (single rate) |
| lsb_first_i | input | 1 | Send lsb first |
| offset_bin_i | input | 1 | Send offset binary |
| smp_valid_i | input | NCH | Per-channel sample strobe |
| smp_data_i | input | NCH*SAMPLE_W | Per-channel samples, channel c at bits c*SAMPLE_W upward |
| ser_a_o | output | NCH | Lane A per channel |
| ser_b_o | output | NCH | Lane B per channel |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |

## Verification
The bench sweeps every lane code against every combination of short frame, capture edge, bit order and format. Each channel gets its own sample value in each sweep step, so channels cannot mask one another. Comparing frames across lane codes shows whether a word splits correctly over two wires. Flipping the order and format bits tells bit reversal apart from an msb inversion, and running the short-frame bit in the double-rate codes shows that it is ignored there. Separate runs with the alignment and alternating patterns, a stop and restart, and a configuration change partway through a frame show where each setting takes hold.

// File: rtl/adcser_pkg.sv
package adcser_pkg;

  typedef enum logic [1:0] {
    MODE_DATA = 2'b00,
    MODE_SYNC = 2'b01,
    MODE_OFF  = 2'b10,
    MODE_SKEW = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  two_wire;
    logic  sdr;
    logic  short_fr;
    logic  cap_rise;
    logic  lsb_first;
    logic  offset_bin;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [1:0] mode, input logic [1:0] lanes,
                                      input logic shrt, input logic rise,
                                      input logic lsb, input logic offs);
    cfg_t c;
    c.mode       = mode_e'(mode);
    c.two_wire   = lanes[1];
    c.sdr        = (lanes == 2'b10);
    c.short_fr   = shrt;
    c.cap_rise   = rise;
    c.lsb_first  = lsb;
    c.offset_bin = offs;
    return c;
  endfunction

endpackage

// File: rtl/adcser_timing.sv
module adcser_timing
  import adcser_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int SHORT_W  = 12,
  parameter int CW       = $clog2(2*SAMPLE_W),
  parameter int NW       = $clog2(SAMPLE_W+1)
) (
  input  logic          clk,
  input  logic          rst,
  input  cfg_t          cfg_in,
  output cfg_t          cfg_q,
  output logic          run,
  output logic          load,
  output logic          alt,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] last,
  output logic [NW-1:0] bit_idx,
  output logic [NW-1:0] lane_bits,
  output logic [NW-1:0] word_bits_q,
  output logic [NW-1:0] word_bits_in,
  output logic          bclk_nxt,
  output logic          fclk_nxt
);

  logic stopped;
  logic half;
  logic boundary;
  logic start;

  function automatic int word_len(input cfg_t c);
    return (c.sdr && c.short_fr) ? SHORT_W : SAMPLE_W;
  endfunction

  function automatic int per_lane(input cfg_t c);
    return c.two_wire ? word_len(c) / 2 : word_len(c);
  endfunction

  always_comb begin
    word_bits_q  = NW'(word_len(cfg_q));
    word_bits_in = NW'(word_len(cfg_in));
    lane_bits    = NW'(per_lane(cfg_q));
    last         = CW'(2 * per_lane(cfg_q) - 1);
    half         = cnt[0];
    bit_idx      = NW'(cnt >> 1);
    run          = !stopped;
    boundary     = run && (cnt == last);
    start        = stopped && (cfg_in.mode != MODE_OFF);
    load         = boundary || start;
    bclk_nxt     = run && (cfg_q.sdr ? (half ^ ~cfg_q.cap_rise) : (half ^ alt));
    fclk_nxt     = run && (int'(cnt) < per_lane(cfg_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stopped <= 1'b1;
      cnt     <= '0;
      alt     <= 1'b0;
      cfg_q   <= cfg_t'('0);
    end else if (load) begin
      cfg_q   <= cfg_in;
      cnt     <= '0;
      stopped <= (cfg_in.mode == MODE_OFF);
      alt     <= start ? 1'b0 : ~alt;
    end else if (run) begin
      cnt <= cnt + 1'b1;
      if (half) alt <= ~alt;
    end
  end

endmodule

// File: rtl/adcser_lane.sv
module adcser_lane
  import adcser_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int NW       = $clog2(SAMPLE_W+1),
  parameter int IW       = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                load,
  input  logic                run,
  input  logic                alt,
  input  cfg_t                cfg_in,
  input  cfg_t                cfg_q,
  input  logic [NW-1:0]       word_bits_in,
  input  logic [NW-1:0]       word_bits_q,
  input  logic [NW-1:0]       lane_bits,
  input  logic [NW-1:0]       bit_idx,
  output logic                a_nxt,
  output logic                b_nxt
);

  logic [SAMPLE_W-1:0] hold;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] fmt;
  logic [IW-1:0]       ia;
  logic [IW-1:0]       ib;
  logic                sync_bit;

  // format at load: keep the low n bits, optionally flip the top one
  always_comb begin
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (i >= int'(word_bits_in))
        fmt[i] = 1'b0;
      else if (cfg_in.offset_bin && (i == int'(word_bits_in) - 1))
        fmt[i] = ~hold[i];
      else
        fmt[i] = hold[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      word <= '0;
    end else begin
      if (smp_valid) hold <= smp_data;
      if (load)      word <= fmt;
    end
  end

  // bit selection for the slot in progress
  always_comb begin
    int n, h, k;
    n = int'(word_bits_q);
    h = n / 2;
    k = int'(bit_idx);
    if (cfg_q.two_wire) begin
      ia = IW'(cfg_q.lsb_first ? h + k : n - 1 - k);
      ib = IW'(cfg_q.lsb_first ? k : h - 1 - k);
    end else begin
      ia = IW'(cfg_q.lsb_first ? k : n - 1 - k);
      ib = '0;
    end
    sync_bit = (k < (int'(lane_bits) + 1) / 2);
    a_nxt = 1'b0;
    b_nxt = 1'b0;
    if (run) begin
      case (cfg_q.mode)
        MODE_DATA: begin
          a_nxt = word[ia];
          b_nxt = cfg_q.two_wire & word[ib];
        end
        MODE_SYNC: begin
          a_nxt = sync_bit;
          b_nxt = cfg_q.two_wire & sync_bit;
        end
        MODE_SKEW: begin
          a_nxt = ~alt;
          b_nxt = cfg_q.two_wire & ~alt;
        end
        default: begin
          a_nxt = 1'b0;
          b_nxt = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_serializer.sv
module adc_serializer
  import adcser_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int SAMPLE_W = 14,
  parameter int SHORT_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode_i,
  input  logic [1:0]              lane_sel_i,
  input  logic                    short_frame_i,
  input  logic                    cap_rise_i,
  input  logic                    lsb_first_i,
  input  logic                    offset_bin_i,
  input  logic [NCH-1:0]          smp_valid_i,
  input  logic [NCH*SAMPLE_W-1:0] smp_data_i,
  output logic [NCH-1:0]          ser_a_o,
  output logic [NCH-1:0]          ser_b_o,
  output logic                    bclk_o,
  output logic                    fclk_o
);

  localparam int CW = $clog2(2*SAMPLE_W);
  localparam int NW = $clog2(SAMPLE_W+1);
  localparam int IW = $clog2(SAMPLE_W);

  cfg_t          cfg_in;
  cfg_t          cfg_q;
  logic          run_w;
  logic          load_w;
  logic          alt_w;
  logic [CW-1:0] cnt_w;
  logic [CW-1:0] last_w;
  logic [NW-1:0] bit_idx_w;
  logic [NW-1:0] lane_bits_w;
  logic [NW-1:0] wbits_q_w;
  logic [NW-1:0] wbits_in_w;
  logic          bclk_nxt;
  logic          fclk_nxt;
  logic [NCH-1:0] a_nxt;
  logic [NCH-1:0] b_nxt;

  assign cfg_in = decode_cfg(mode_i, lane_sel_i, short_frame_i, cap_rise_i,
                             lsb_first_i, offset_bin_i);

  adcser_timing #(
    .SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W), .CW(CW), .NW(NW)
  ) u_timing (
    .clk(clk), .rst(rst), .cfg_in(cfg_in), .cfg_q(cfg_q),
    .run(run_w), .load(load_w), .alt(alt_w), .cnt(cnt_w), .last(last_w),
    .bit_idx(bit_idx_w), .lane_bits(lane_bits_w),
    .word_bits_q(wbits_q_w), .word_bits_in(wbits_in_w),
    .bclk_nxt(bclk_nxt), .fclk_nxt(fclk_nxt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    adcser_lane #(.SAMPLE_W(SAMPLE_W), .NW(NW), .IW(IW)) u_lane (
      .clk(clk), .rst(rst),
      .smp_valid(smp_valid_i[c]),
      .smp_data(smp_data_i[c*SAMPLE_W +: SAMPLE_W]),
      .load(load_w), .run(run_w), .alt(alt_w),
      .cfg_in(cfg_in), .cfg_q(cfg_q),
      .word_bits_in(wbits_in_w), .word_bits_q(wbits_q_w),
      .lane_bits(lane_bits_w), .bit_idx(bit_idx_w),
      .a_nxt(a_nxt[c]), .b_nxt(b_nxt[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_a_o <= '0;
      ser_b_o <= '0;
      bclk_o  <= 1'b0;
      fclk_o  <= 1'b0;
    end else begin
      ser_a_o <= a_nxt;
      ser_b_o <= b_nxt;
      bclk_o  <= bclk_nxt;
      fclk_o  <= fclk_nxt;
    end
  end

endmodule

// File: rtl/adcser_check.sv
module adcser_check
  import adcser_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           run,
  input logic           load,
  input cfg_t           cfg_q,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  last,
  input logic [NCH-1:0] ser_a_o,
  input logic [NCH-1:0] ser_b_o,
  input logic           bclk_o,
  input logic           fclk_o
);

  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!bclk_o && !fclk_o && ser_a_o == '0 && ser_b_o == '0));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= last));

  assert_sdr_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (run && cfg_q.sdr && $past(run) && !$past(load)) |=> (bclk_o != $past(bclk_o)));

  assert_ddr_slot_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !cfg_q.sdr && !cnt[0] && $past(run) && !$past(load)) |=> (bclk_o == $past(bclk_o)));

  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg_q));

endmodule

bind adc_serializer adcser_check #(.NCH(NCH), .CW(CW)) u_check (
  .clk(clk), .rst(rst), .run(run_w), .load(load_w), .cfg_q(cfg_q),
  .cnt(cnt_w), .last(last_w), .ser_a_o(ser_a_o), .ser_b_o(ser_b_o),
  .bclk_o(bclk_o), .fclk_o(fclk_o)
);

// File: tb/test_adc_serializer.sv
module test_adc_serializer;

  localparam int NCH = 2;
  localparam int W   = 14;
  localparam int SW  = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       mode_i = 2'b00;
  logic [1:0]       lane_sel_i = 2'b00;
  logic             short_frame_i = 1'b0;
  logic             cap_rise_i = 1'b0;
  logic             lsb_first_i = 1'b0;
  logic             offset_bin_i = 1'b0;
  logic [NCH-1:0]   smp_valid_i = '0;
  logic [NCH*W-1:0] smp_data_i = '0;
  logic [NCH-1:0]   ser_a_o;
  logic [NCH-1:0]   ser_b_o;
  logic             bclk_o;
  logic             fclk_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [1:0] e_mode, e_ls, p_mode, p_ls;
  logic e_sh, e_cr, e_lb, e_ob, p_sh, p_cr, p_lb, p_ob;
  logic [W-1:0] e_smp [NCH];
  int chg_at = -1;

  adc_serializer #(.NCH(NCH), .SAMPLE_W(W), .SHORT_W(SW)) i_adc_serializer (
    .clk(clk), .rst(rst), .mode_i(mode_i), .lane_sel_i(lane_sel_i),
    .short_frame_i(short_frame_i), .cap_rise_i(cap_rise_i),
    .lsb_first_i(lsb_first_i), .offset_bin_i(offset_bin_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .ser_a_o(ser_a_o), .ser_b_o(ser_b_o), .bclk_o(bclk_o), .fclk_o(fclk_o)
  );

  always #2.5 clk = ~clk;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog R1 got=hung exp=done");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input string what, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] md, input logic [1:0] ls, input logic sh,
                       input logic cr, input logic lb, input logic ob);
    mode_i = md; lane_sel_i = ls; short_frame_i = sh;
    cap_rise_i = cr; lsb_first_i = lb; offset_bin_i = ob;
  endtask

  task automatic setup(input logic [1:0] md, input logic [1:0] ls, input logic sh,
                       input logic cr, input logic lb, input logic ob);
    drive(md, ls, sh, cr, lb, ob);
    e_mode = md; e_ls = ls; e_sh = sh; e_cr = cr; e_lb = lb; e_ob = ob;
  endtask

  task automatic send(input int seed);
    for (int c = 0; c < NCH; c++) begin
      e_smp[c] = W'((seed * 1237 + c * 4093 + 77) % 16384);
      smp_data_i[c*W +: W] = e_smp[c];
    end
    smp_valid_i = '1;
    @(negedge clk);
    smp_valid_i = '0;
  endtask

  task automatic wait_rise();
    logic pf;
    do begin
      pf = fclk_o;
      @(negedge clk);
    end while (!(fclk_o && !pf));
  endtask

  // expected data bit from the requirement text (R4, R7, R8, R9, R13)
  function automatic logic exp_bit(input logic [1:0] ls, input logic sh, input logic lb,
                                   input logic ob, input logic [W-1:0] s,
                                   input int lane, input int k);
    logic [W-1:0] w;
    int n, h;
    n = (ls == 2'b10 && sh) ? SW : W;
    h = n / 2;
    w = s;
    for (int i = 0; i < W; i++) if (i >= n) w[i] = 1'b0;
    if (ob) w[n-1] = ~w[n-1];
    if (!ls[1]) return (lane == 0) ? w[lb ? k : n-1-k] : 1'b0;
    if (lane == 0) return w[lb ? h+k : n-1-k];
    return w[lb ? k : h-1-k];
  endfunction

  // called at the negedge where the frame clock has just risen
  task automatic check_frame(input string dreq);
    int n, m;
    logic two, sdr;
    logic fa [2*W];
    logic ba [2*W];
    logic [NCH-1:0] sa [2*W];
    logic [NCH-1:0] sb [2*W];
    two = e_ls[1];
    sdr = (e_ls == 2'b10);
    n = (sdr && e_sh) ? SW : W;
    m = two ? n / 2 : n;
    for (int c = 0; c < 2*m; c++) begin
      if (c > 0) @(negedge clk);
      if (c == chg_at) drive(p_mode, p_ls, p_sh, p_cr, p_lb, p_ob);
      fa[c] = fclk_o; ba[c] = bclk_o; sa[c] = ser_a_o; sb[c] = ser_b_o;
    end
    begin : fclk_chk
      int gv, ev;
      bit ok;
      ok = 1; gv = 0; ev = 0;
      for (int c = 0; c < 2*m; c++) begin
        gv[c] = fa[c];
        ev[c] = (c < m);
        if (fa[c] != (c < m)) ok = 0;
      end
      chk(ok, "R3", "frame clock", gv, ev);
    end
    begin : bclk_chk
      int gv;
      bit ok;
      ok = 1; gv = 0;
      for (int c = 0; c < 2*m; c++) begin
        gv[c] = ba[c];
        if (sdr) begin
          if (ba[c] != (c[0] ^ ~e_cr)) ok = 0;
        end else if (c > 0) begin
          if (c[0] && ba[c] == ba[c-1]) ok = 0;
          if (!c[0] && ba[c] != ba[c-1]) ok = 0;
        end
      end
      chk(ok, sdr ? "R5" : "R6", "bit clock", gv, sdr ? -1 : -2);
    end
    for (int ch = 0; ch < NCH; ch++) begin
      for (int ln = 0; ln < 2; ln++) begin
        int gv, ev;
        bit ok;
        ok = 1; gv = 0; ev = 0;
        for (int k = 0; k < m; k++) begin
          logic g0, g1, e;
          g0 = (ln == 0) ? sa[2*k][ch] : sb[2*k][ch];
          g1 = (ln == 0) ? sa[2*k+1][ch] : sb[2*k+1][ch];
          gv[k] = g0;
          if (g0 != g1) ok = 0;
          if (e_mode == 2'b00) e = exp_bit(e_ls, e_sh, e_lb, e_ob, e_smp[ch], ln, k);
          else if (e_mode == 2'b01) e = (ln == 1 && !two) ? 1'b0 : (k < (m + 1) / 2);
          else if (ln == 1 && !two) e = 1'b0;
          else e = (k == 0) ? g0 : ~gv[k-1];
          if (e_mode == 2'b11 && two && sa[2*k][ch] != sb[2*k][ch]) ok = 0;
          ev[k] = e;
          if (g0 != e) ok = 0;
        end
        chk(ok, dreq, $sformatf("ch%0d lane%0d", ch, ln), gv, ev);
      end
    end
  endtask

  initial begin
    // R1: reset state
    setup(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < NCH; c++) e_smp[c] = '0;
    repeat (4) @(negedge clk);
    chk(ser_a_o == '0 && ser_b_o == '0 && !bclk_o && !fclk_o, "R1", "outputs in reset",
        {ser_a_o, ser_b_o, bclk_o, fclk_o}, 0);
    rst = 1'b0;
    wait_rise();
    check_frame("R1");

    // sweep of lane codes, short frame, edge, order, format (R4 R5 R6 R7 R8 R9 R13)
    for (int li = 0; li < 4; li++) begin
      for (int v = 0; v < 16; v++) begin
        setup(2'b00, 2'(li), v[3], v[2], v[1], v[0]);
        send(li * 16 + v);
        wait_rise();
        wait_rise();
        if (li == 1) check_frame("R13");
        else if (li == 2) check_frame(v[3] ? "R4_R8_R9" : "R8_R9");
        else if (li == 3) check_frame("R4_R8_R9");
        else check_frame("R4_R7_R9");
      end
    end

    // training patterns (R10 R11)
    for (int li = 0; li < 4; li++) begin
      if (li == 1) continue;
      for (int sh = 0; sh < 2; sh++) begin
        setup(2'b01, 2'(li), sh[0], 1'b1, 1'b0, 1'b0);
        wait_rise(); wait_rise();
        check_frame("R10");
        setup(2'b11, 2'(li), sh[0], 1'b0, 1'b1, 1'b0);
        wait_rise(); wait_rise();
        check_frame("R11");
      end
    end

    // R12 and R14: change in mid-frame, then a frame with the held sample
    setup(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    send(999);
    wait_rise(); wait_rise();
    p_mode = 2'b00; p_ls = 2'b11; p_sh = 1'b0; p_cr = 1'b0; p_lb = 1'b1; p_ob = 1'b1;
    chg_at = 5;
    check_frame("R12");
    chg_at = -1;
    setup(p_mode, p_ls, p_sh, p_cr, p_lb, p_ob);
    wait_rise();
    check_frame("R12_R14");

    // R2: stop, quiet outputs, restart
    setup(2'b10, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (64) @(negedge clk);
    begin : quiet
      bit ok;
      int gv;
      ok = 1; gv = 0;
      for (int c = 0; c < 40; c++) begin
        if (ser_a_o != '0 || ser_b_o != '0 || bclk_o || fclk_o) begin
          ok = 0;
          gv = {ser_a_o, ser_b_o, bclk_o, fclk_o};
        end
        @(negedge clk);
      end
      chk(ok, "R2", "stopped outputs", gv, 0);
    end
    setup(2'b00, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
    begin : restart
      int waited;
      waited = 0;
      while (!fclk_o && waited < 4) begin
        @(negedge clk);
        waited++;
      end
      chk(fclk_o && waited <= 2, "R2", "restart delay", waited, 1);
    end
    check_frame("R2_R14");

    finish_run();
  end

endmodule